// File: doc/BRIEF.md
# Flash Status and Interrupt Controller

This block sits between a processor bus and an embedded flash array whose erase and program sequences run on their own. Half-word reads of the flash window go to the array with one inserted wait state. Writes to the window are passed on to the flash as command strobes. A status register at a fixed address outside the window shows the ready/busy state of the flash, a completion flag and an interrupt enable.

While the flash reports busy, the block drops any command write and answers a read from the window with the flash's sequence flag instead of array data. When the flash returns from busy to ready, the completion flag is latched. The interrupt output is high whenever both that flag and the enable are set. Software removes the request by writing zero to either bit.

The ready/busy line is brought in through a synchronizer chain, and every decision uses the synchronized value. The bus is a request/acknowledge handshake. The requester holds a request until it sees a one-cycle acknowledge.

Top module: `flash_status_ctrl`

## Requirements
- R1: A half-word read inside the flash window while ready is acknowledged in the second cycle after the request is sampled. It returns the array data for that address and raises the flash read enable for exactly one cycle, with the requested address.
- R2: A word-size read (bus_word=1) inside the flash window is acknowledged one cycle after sampling with bus_err=1 and read data 0, and no flash read is started.
- R3: A read of the status address is acknowledged after one cycle and returns RDY in bit 0 (1 = ready, 0 = busy, following the synchronized ready input), RDYINT in bit 1, INTE in bit 2 and 0 in every other bit.
- R4: A half-word window read while the synchronized ready is 0 returns the value on fl_seq_flag instead of array data, with the same two-cycle timing.
- R5: A write inside the window while ready is acknowledged after one cycle, with no error. In the same cycle as the acknowledge, cmd_stb is high for one cycle and carries the write address and data.
- R6: A write inside the window while busy is acknowledged but produces no cmd_stb.
- R7: RDYINT becomes 1 only after a busy-to-ready change of the synchronized ready input. Writing 1 to status bit 1 never sets it.
- R8: irq is 1 exactly when RDYINT and INTE are both 1.
- R9: INTE takes status write bit 2. Writing 0 to bit 1 clears RDYINT. Either write removes irq.
- R10: When a busy-to-ready change and a write clearing RDYINT fall in the same cycle, RDYINT ends up 1.
- R11: After reset, INTE and RDYINT are 0 and irq is 0. With the ready input held high, RDY reads 1.
- R12: An access to an address neither in the window nor at the status address is acknowledged after one cycle with data 0 and no error, and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access size, 0 = half-word |
| bus_addr | input | ADDR_W | Half-word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_err | output | 1 | Error response, valid with bus_ack |
| fl_ready | input | 1 | Asynchronous flash ready (1) / busy (0) |
| fl_seq_flag | input | DATA_W | Flash sequence flag returned while busy |
| fl_rd_en | output | 1 | Array read enable |
| fl_rd_addr | output | ADDR_W | Array read address |
| fl_rd_data | input | DATA_W | Array read data for fl_rd_addr |
| cmd_stb | output | 1 | One-cycle command write strobe |
| cmd_addr | output | ADDR_W | Command address, valid with cmd_stb |
| cmd_data | output | DATA_W | Command data, valid with cmd_stb |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench builds the block with a 16-bit address, a 256-entry flash window based at 0x1000, the status register at 0x2000 and a two-stage synchronizer. The small window lets random addresses land often on both edges of the window (0x0FFF, 0x1000, 0x10FF, 0x1100) and on the status address. Because the synchronizer is short, the bench can put a busy-to-ready change in exactly the same cycle as a status write that clears RDYINT. Random traffic mixes reads, writes and word-size accesses with ready/busy toggles and changing sequence flag values.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [0:0] {
    BS_IDLE   = 1'b0,
    BS_RDWAIT = 1'b1
  } bus_state_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ARRAY = 2'd1,
    TGT_STAT  = 2'd2
  } target_e;

  localparam int STAT_RDY_BIT    = 0;
  localparam int STAT_RDYINT_BIT = 1;
  localparam int STAT_INTE_BIT   = 2;
endpackage

// File: rtl/fsc_rdy_sync.sv
module fsc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_async,
  output logic rdy_sync,
  output logic ready_rise
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = rdy_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], rdy_async};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  // Reset to the ready value so a flash that is ready at reset gives no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rdy_sync   = chain_q[STAGES-1];
  assign ready_rise = chain_q[STAGES-1] & ~prev_q;

  assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_rise |=> !ready_rise);
endmodule

// File: rtl/fsc_stat_reg.sv
module fsc_stat_reg import fsc_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_sync,
  input  logic              ready_rise,
  input  logic              wr_en,
  input  logic              wr_rdyint,
  input  logic              wr_inte,
  output logic [DATA_W-1:0] stat_word,
  output logic              irq
);
  logic rdyint_q, rdyint_d;
  logic inte_q, inte_d;
  logic rdyint_en, inte_en;

  always_comb begin
    inte_en   = wr_en;
    inte_d    = wr_inte;
    // A completion edge wins over a software clear in the same cycle.
    rdyint_en = ready_rise | (wr_en & ~wr_rdyint);
    rdyint_d  = ready_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdyint_q <= 1'b0;
      inte_q   <= 1'b0;
    end else begin
      if (rdyint_en) rdyint_q <= rdyint_d;
      if (inte_en)   inte_q   <= inte_d;
    end
  end

  always_comb begin
    stat_word                  = '0;
    stat_word[STAT_RDY_BIT]    = rdy_sync;
    stat_word[STAT_RDYINT_BIT] = rdyint_q;
    stat_word[STAT_INTE_BIT]   = inte_q;
  end

  assign irq = rdyint_q & inte_q;

  assert_set_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_rise |=> rdyint_q);
  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_rise && !rdyint_q) |=> !rdyint_q);
  assert_inte_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_inte) |=> !irq);
  assert_flag_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_rdyint && !ready_rise) |=> !irq);
endmodule

// File: rtl/fsc_bus_ctrl.sv
module fsc_bus_ctrl import fsc_pkg::*; #(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 16,
  parameter int              WIN_LOG2   = 12,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic              rdy_sync,
  input  logic [DATA_W-1:0] stat_word,
  input  logic [DATA_W-1:0] fl_seq_flag,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              fl_rd_en,
  output logic [ADDR_W-1:0] fl_rd_addr,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              stat_wr_en,
  output logic              stat_wr_rdyint,
  output logic              stat_wr_inte
);
  localparam int TAG_MSB = ADDR_W - 1;

  bus_state_e        state_q, state_d;
  target_e           tgt;
  logic              start;
  logic              ack_q, ack_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic [ADDR_W-1:0] raddr_q;
  logic              raddr_en;
  logic              stb_q, stb_d;
  logic              cmd_en;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [DATA_W-1:0] cmd_data_q;

  always_comb begin
    if (bus_addr[TAG_MSB:WIN_LOG2] == FLASH_BASE[TAG_MSB:WIN_LOG2]) tgt = TGT_ARRAY;
    else if (bus_addr == STAT_ADDR)                                   tgt = TGT_STAT;
    else                                                              tgt = TGT_NONE;
  end

  assign start = (state_q == BS_IDLE) && bus_req && !ack_q;

  always_comb begin
    state_d  = state_q;
    ack_d    = 1'b0;
    err_d    = 1'b0;
    rdata_en = 1'b0;
    rdata_d  = '0;
    raddr_en = 1'b0;
    stb_d    = 1'b0;
    cmd_en   = 1'b0;
    unique case (state_q)
      BS_IDLE: begin
        if (start) begin
          unique case (tgt)
            TGT_ARRAY: begin
              if (!bus_we && !bus_word) begin
                state_d  = BS_RDWAIT;
                raddr_en = 1'b1;
              end else if (!bus_we) begin
                ack_d    = 1'b1;
                err_d    = 1'b1;
                rdata_en = 1'b1;
              end else begin
                ack_d    = 1'b1;
                rdata_en = 1'b1;
                stb_d    = rdy_sync;
                cmd_en   = rdy_sync;
              end
            end
            TGT_STAT: begin
              ack_d    = 1'b1;
              rdata_en = 1'b1;
              rdata_d  = bus_we ? '0 : stat_word;
            end
            default: begin
              ack_d    = 1'b1;
              rdata_en = 1'b1;
            end
          endcase
        end
      end
      BS_RDWAIT: begin
        state_d  = BS_IDLE;
        ack_d    = 1'b1;
        rdata_en = 1'b1;
        rdata_d  = rdy_sync ? fl_rd_data : fl_seq_flag;
      end
      default: state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BS_IDLE;
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
      stb_q      <= 1'b0;
      rdata_q    <= '0;
      raddr_q    <= '0;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      stb_q   <= stb_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (raddr_en) raddr_q <= bus_addr;
      if (cmd_en) begin
        cmd_addr_q <= bus_addr;
        cmd_data_q <= bus_wdata;
      end
    end
  end

  assign bus_ack    = ack_q;
  assign bus_err    = err_q;
  assign bus_rdata  = rdata_q;
  assign fl_rd_en   = (state_q == BS_RDWAIT);
  assign fl_rd_addr = raddr_q;
  assign cmd_stb    = stb_q;
  assign cmd_addr   = cmd_addr_q;
  assign cmd_data   = cmd_data_q;

  assign stat_wr_en     = start && (tgt == TGT_STAT) && bus_we;
  assign stat_wr_rdyint = bus_wdata[STAT_RDYINT_BIT];
  assign stat_wr_inte   = bus_wdata[STAT_INTE_BIT];

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  assert_read_one_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_en |=> (bus_ack && !fl_rd_en));
  assert_err_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ack && !fl_rd_en));
  assert_cmd_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (bus_ack && !bus_err));
  assert_no_cmd_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(rdy_sync));
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl import fsc_pkg::*; #(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 16,
  parameter int              WIN_LOG2    = 12,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'h8000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic              fl_ready,
  input  logic [DATA_W-1:0] fl_seq_flag,
  output logic              fl_rd_en,
  output logic [ADDR_W-1:0] fl_rd_addr,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              irq
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              rdy_sync;
  logic              ready_rise;
  logic [DATA_W-1:0] stat_word;
  logic              stat_wr_en;
  logic              stat_wr_rdyint;
  logic              stat_wr_inte;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  fsc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rdy_async (fl_ready),
    .rdy_sync  (rdy_sync),
    .ready_rise(ready_rise)
  );

  fsc_stat_reg #(.DATA_W(DATA_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rdy_sync  (rdy_sync),
    .ready_rise(ready_rise),
    .wr_en     (stat_wr_en),
    .wr_rdyint (stat_wr_rdyint),
    .wr_inte   (stat_wr_inte),
    .stat_word (stat_word),
    .irq       (irq)
  );

  fsc_bus_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_LOG2  (WIN_LOG2),
    .FLASH_BASE(FLASH_BASE),
    .STAT_ADDR (STAT_ADDR)
  ) u_bus (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_word      (bus_word),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_ack       (bus_ack),
    .bus_err       (bus_err),
    .rdy_sync      (rdy_sync),
    .stat_word     (stat_word),
    .fl_seq_flag   (fl_seq_flag),
    .fl_rd_data    (fl_rd_data),
    .fl_rd_en      (fl_rd_en),
    .fl_rd_addr    (fl_rd_addr),
    .cmd_stb       (cmd_stb),
    .cmd_addr      (cmd_addr),
    .cmd_data      (cmd_data),
    .stat_wr_en    (stat_wr_en),
    .stat_wr_rdyint(stat_wr_rdyint),
    .stat_wr_inte  (stat_wr_inte)
  );

  assert_irq_needs_inte_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> stat_word[STAT_INTE_BIT] && stat_word[STAT_RDYINT_BIT]);
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> !irq);
endmodule

// File: tb/tb_flash_status_ctrl.sv
module tb_flash_status_ctrl;
  localparam int              ADDR_W = 16;
  localparam int              DATA_W = 16;
  localparam int              WIN_LOG2 = 8;
  localparam logic [15:0]     BASE = 16'h1000;
  localparam logic [15:0]     STAT = 16'h2000;
  localparam logic [15:0]     SCRAMBLE = 16'hA5C3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, bus_req, bus_we, bus_word, bus_ack, bus_err;
  logic [ADDR_W-1:0] bus_addr, fl_rd_addr, cmd_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata, fl_seq_flag, fl_rd_data, cmd_data;
  logic              fl_ready, fl_rd_en, cmd_stb, irq;

  assign fl_rd_data = fl_rd_addr ^ SCRAMBLE;

  flash_status_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2),
    .FLASH_BASE(BASE), .STAT_ADDR(STAT), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .fl_ready(fl_ready), .fl_seq_flag(fl_seq_flag), .fl_rd_en(fl_rd_en),
    .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data), .cmd_stb(cmd_stb), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  int rd_cnt = 0;
  logic [ADDR_W-1:0] stb_addr, rd_addr_seen;
  logic [DATA_W-1:0] stb_data;
  bit exp_rdy, exp_rdyint, exp_inte;

  always @(negedge clk) begin
    if (cmd_stb) begin stb_cnt++; stb_addr = cmd_addr; stb_data = cmd_data; end
    if (fl_rd_en) begin rd_cnt++; rd_addr_seen = fl_rd_addr; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [15:0] stat_exp();
    return {13'b0, exp_inte, exp_rdyint, exp_rdy};
  endfunction

  function automatic int tgt_of(input logic [15:0] a);
    if (a[15:WIN_LOG2] == BASE[15:WIN_LOG2]) return 1;
    if (a == STAT) return 2;
    return 0;
  endfunction

  task automatic xfer(input bit we, input bit word, input logic [15:0] a, input logic [15:0] wd,
                      output logic [15:0] rd, output logic er, output int cyc);
    bus_req = 1'b1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = wd;
    cyc = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (bus_ack || cyc >= 20) break;
    end
    rd = bus_rdata; er = bus_err;
    bus_req = 1'b0;
  endtask

  task automatic set_ready(input bit v);
    fl_ready = v;
    repeat (4) @(negedge clk);
    if (v && !exp_rdy) exp_rdyint = 1'b1;
    exp_rdy = v;
  endtask

  task automatic do_op(input bit we, input bit word, input logic [15:0] a, input logic [15:0] wd);
    logic [15:0] rd;
    logic er;
    int cyc, s0, r0, t;
    s0 = stb_cnt; r0 = rd_cnt; t = tgt_of(a);
    xfer(we, word, a, wd, rd, er, cyc);
    @(negedge clk);
    if (t == 1 && !we && !word) begin
      if (exp_rdy) begin
        chk("R1 read cycles", cyc, 2);
        chk("R1 read data", rd, a ^ SCRAMBLE);
        chk("R1 read enable count", rd_cnt - r0, 1);
        chk("R1 read address", rd_addr_seen, a);
      end else begin
        chk("R4 busy read cycles", cyc, 2);
        chk("R4 busy read flag", rd, fl_seq_flag);
      end
      chk("R1 read err", er, 0);
    end else if (t == 1 && !we) begin
      chk("R2 word err", er, 1);
      chk("R2 word cycles", cyc, 1);
      chk("R2 word data", rd, 0);
      chk("R2 no flash read", rd_cnt - r0, 0);
    end else if (t == 1) begin
      chk("R5 write cycles", cyc, 1);
      chk("R5 write err", er, 0);
      if (exp_rdy) begin
        chk("R5 strobe count", stb_cnt - s0, 1);
        chk("R5 strobe addr", stb_addr, a);
        chk("R5 strobe data", stb_data, wd);
      end else begin
        chk("R6 dropped strobe", stb_cnt - s0, 0);
      end
    end else if (t == 2) begin
      chk("R3 status cycles", cyc, 1);
      if (!we) chk("R3 status word", rd, stat_exp());
      else begin
        exp_inte = wd[2];
        if (!wd[1]) exp_rdyint = 1'b0;
      end
    end else begin
      chk("R12 unmapped cycles", cyc, 1);
      chk("R12 unmapped data", rd, 0);
      chk("R12 unmapped err", er, 0);
      chk("R12 unmapped no strobe", stb_cnt - s0, 0);
      chk("R12 unmapped no read", rd_cnt - r0, 0);
    end
    chk("R8 irq", irq, exp_rdyint & exp_inte);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] rd, a;
    logic er;
    int cyc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    fl_ready = 1'b1; fl_seq_flag = 16'h00C5;
    exp_rdy = 1; exp_rdyint = 0; exp_inte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 irq after reset", irq, 0);
    xfer(0, 0, STAT, 16'h0, rd, er, cyc);
    @(negedge clk);
    chk("R11 status after reset", rd, 16'h0001);

    // directed R1, R2, R5, R12, R3
    do_op(1, 0, STAT, 16'h0004);
    do_op(0, 0, 16'h1000, 0);
    do_op(0, 0, 16'h10FF, 0);
    do_op(0, 1, 16'h1010, 0);
    do_op(1, 0, 16'h1022, 16'h5A5A);
    do_op(0, 0, 16'h0FFF, 0);
    do_op(1, 0, 16'h1100, 16'h1234);
    do_op(0, 0, STAT, 0);

    // R4, R6, R3 while busy
    set_ready(0);
    do_op(0, 0, STAT, 0);
    do_op(0, 0, 16'h1044, 0);
    do_op(1, 0, 16'h1044, 16'hBEEF);
    // R7, R8 completion
    set_ready(1);
    chk("R7 flag set on completion", irq, 1);
    do_op(0, 0, STAT, 0);
    // R7 writing 1 to flag has no effect; R9 clearing
    do_op(1, 0, STAT, 16'h0006);
    do_op(1, 0, STAT, 16'h0004);
    chk("R9 irq after flag clear", irq, 0);
    do_op(1, 0, STAT, 16'h0006);
    chk("R7 write one does not set", irq, 0);
    set_ready(0); set_ready(1);
    do_op(1, 0, STAT, 16'h0002);
    chk("R9 irq after enable clear", irq, 0);
    do_op(0, 0, STAT, 0);
    do_op(1, 0, STAT, 16'h0006);
    chk("R8 irq back on", irq, 1);
    do_op(1, 0, STAT, 16'h0000);

    // R10 set wins over same-cycle clear
    set_ready(0);
    fl_ready = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    xfer(1, 0, STAT, 16'h0004, rd, er, cyc);
    @(negedge clk);
    exp_rdy = 1; exp_rdyint = 1; exp_inte = 1;
    chk("R10 set wins irq", irq, 1);
    do_op(0, 0, STAT, 0);
    do_op(1, 0, STAT, 16'h0004);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) set_ready(!exp_rdy);
      else if (r == 1) fl_seq_flag = 16'($urandom);
      else begin
        int s;
        s = $urandom % 8;
        case (s)
          0: a = STAT;
          1: a = 16'h0FFF;
          2: a = 16'h1100;
          3: a = 16'($urandom);
          default: a = BASE | 16'($urandom % 256);
        endcase
        if (a == STAT && ($urandom % 2) == 1)
          do_op(1, 0, a, 16'($urandom % 8));
        else
          do_op(1'($urandom), 1'(($urandom % 4) == 0), a, 16'($urandom));
      end
    end
    finish_run();
  end
endmodule